// File: doc/BRIEF.md
# Serial Transmitter with Break and Preamble Insertion

This block turns bytes written over a small register interface into asynchronous serial frames on one output line. A frame is a low start bit, eight or nine data bits sent least significant first, and a high stop bit. Each bit lasts sixteen pulses of an external baud enable. In nine-bit mode the extra data bit comes from a control field, not from the data write. Two flags show whether the data register can take another byte and whether the line has gone quiet. Each flag has its own interrupt enable, and both feed one interrupt output.

Two control sequences insert special frames after the frame now on the line. Setting the send-break field makes a frame of zeros, stop position included. Clearing the transmit enable and setting it again while a frame is going out makes a frame of ones. Both special frames follow the current word length. While the transmit enable is low the line is held high and no new frame starts.

Top module: `uart_tx_ctl`

## Requirements
- R1: After reset, txd is 1, tdre is 1, tc is 1, irq is 0, and every control field is 0.
- R2: A write to address 0 with the enable on produces a frame: a 0 start bit, data bits 0 to 7 in that order, then a 1 stop bit. Each bit holds for 16 baud_tick pulses.
- R3: When address 1 bit 0 is 1 (nine-bit mode), a ninth data bit is sent after bit 7. Its value is address 1 bit 1, taken when the frame starts.
- R4: A write to address 0 clears tdre. tdre sets again in the cycle the stored byte is moved into the shifter, which starts a frame.
- R5: tc sets when a stop bit ends and no byte, break or preamble is waiting and send-break is 0. A write to address 0 or the start of any frame clears it.
- R6: With the enable (address 2 bit 0) at 0, txd is 1 and no frame starts. A waiting byte goes out once the enable is set again.
- R7: If the enable goes from 0 to 1 while a frame is being shifted, one frame of all ones is sent after that frame. Its length follows the nine-bit mode.
- R8: If send-break (address 2 bit 1) goes from 0 to 1, one all-zero frame is sent after the current frame, even if the field is cleared before then. While the field stays 1, all-zero frames repeat.
- R9: When several frames are waiting, a break goes first, then a preamble, then the data byte.
- R10: irq is 1 exactly when (address 2 bit 2 and tdre) or (address 2 bit 3 and tc).
- R11: A byte written during a frame starts one clock after that frame's stop bit ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data, 1 format, 2 control |
| wr_data | input | 8 | Write value |
| txd | output | 1 | Serial line, idle high |
| tdre | output | 1 | Data register empty flag |
| tc | output | 1 | Transmission complete flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Some properties are checked on every cycle. The line does not change inside a bit period. tdre can rise only when a stored byte enters the shifter, and tc only as a frame ends. A data write always clears both flags on the next cycle.

Other behaviour depends on order and history, so only the bench scenarios can show it. This covers the order of queued break, preamble and data frames, and a preamble caused by an enable pulse rather than a plain set. It also covers a single break surviving a quick set and clear, the ninth bit value, and the line staying high while the enable is off. A step-by-step model of the line, compared on every clock, covers these.

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl #(
  parameter int DATA_W = 8,
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tdre,
  output logic              tc,
  output logic              irq
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [DATA_W-1:0] dr;
  logic              dr_full, nine, ninth;
  logic              te, sbk, tie, tcie;
  logic              brk_pend, pre_pend, busy;
  logic [FW-1:0]     sh;
  logic [CW-1:0]     bcnt, len;
  logic [TW-1:0]     tcnt;

  wire send_brk = sbk | brk_pend;
  wire start    = !busy && te && (send_brk || pre_pend || dr_full);
  wire bit_end  = busy && baud_tick && (tcnt == TW'(OVS - 1));
  wire last     = bit_end && (bcnt == len - CW'(1));
  wire wr_dat   = wr_en && (wr_addr == 2'd0);
  wire wr_fmt   = wr_en && (wr_addr == 2'd1);
  wire wr_ctl   = wr_en && (wr_addr == 2'd2);

  wire [FW-1:0] data_frame = nine ? {1'b1, ninth, dr, 1'b0} : {2'b11, dr, 1'b0};

  assign txd = (te && busy) ? sh[0] : 1'b1;
  assign irq = (tie && tdre) || (tcie && tc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr <= '0; dr_full <= 1'b0; nine <= 1'b0; ninth <= 1'b0;
      te <= 1'b0; sbk <= 1'b0; tie <= 1'b0; tcie <= 1'b0;
      brk_pend <= 1'b0; pre_pend <= 1'b0; busy <= 1'b0;
      sh <= '1; bcnt <= '0; len <= '0; tcnt <= '0;
      tdre <= 1'b1; tc <= 1'b1;
    end else begin
      if (start) begin
        busy <= 1'b1;
        tcnt <= '0;
        bcnt <= '0;
        tc   <= 1'b0;
        len  <= nine ? CW'(FW) : CW'(FW - 1);
        if (send_brk) begin
          sh <= '0;
          brk_pend <= 1'b0;
        end else if (pre_pend) begin
          sh <= '1;
          pre_pend <= 1'b0;
        end else begin
          sh <= data_frame;
          dr_full <= 1'b0;
          tdre <= 1'b1;
        end
      end else if (busy && baud_tick) begin
        if (bit_end) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          bcnt <= bcnt + CW'(1);
          if (last) begin
            busy <= 1'b0;
            tc   <= !(dr_full || brk_pend || pre_pend || sbk);
          end
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end

      if (wr_dat) begin
        dr <= wr_data;
        dr_full <= 1'b1;
        tdre <= 1'b0;
        tc <= 1'b0;
      end
      if (wr_fmt) begin
        nine  <= wr_data[0];
        ninth <= wr_data[1];
      end
      if (wr_ctl) begin
        te   <= wr_data[0];
        sbk  <= wr_data[1];
        tie  <= wr_data[2];
        tcie <= wr_data[3];
        if (busy && !te && wr_data[0]) pre_pend <= 1'b1;
        if (!sbk && wr_data[1]) brk_pend <= 1'b1;
      end
    end
  end

  // R4
  tdre_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdre) |-> busy && $past(dr_full));

  // R5
  tc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> !busy && $past(busy));

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(bit_end) && te && $past(te) |-> $stable(txd));

  // R4
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> !tdre && !tc);
endmodule

// File: tb/uart_tx_ctl_bench.sv
module uart_tx_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic txd, tdre, tc, irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit comparing = 1'b0;

  always #4 clk = ~clk;

  uart_tx_ctl u_uart_tx_ctl (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .txd(txd), .tdre(tdre), .tc(tc), .irq(irq)
  );

  // reference model state
  bit m_busy, m_full, m_tdre, m_tc, m_brk, m_pre;
  bit m_nine, m_ninth, m_te, m_sbk, m_tie, m_tcie;
  logic [7:0] m_dr;
  int m_ph;
  bit bits[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_tdre = 1; m_tc = 1; m_brk = 0; m_pre = 0;
      m_nine = 0; m_ninth = 0; m_te = 0; m_sbk = 0; m_tie = 0; m_tcie = 0;
      m_dr = 8'd0; m_ph = 0; bits.delete();
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (!m_busy) begin
        if (m_te && (m_sbk || m_brk || m_pre || m_full)) begin
          int n;
          n = m_nine ? 11 : 10;
          bits.delete();
          if (m_sbk || m_brk) begin
            for (int i = 0; i < n; i++) bits.push_back(1'b0);
            m_brk = 0;
          end else if (m_pre) begin
            for (int i = 0; i < n; i++) bits.push_back(1'b1);
            m_pre = 0;
          end else begin
            bits.push_back(1'b0);
            for (int i = 0; i < 8; i++) bits.push_back(m_dr[i]);
            if (m_nine) bits.push_back(m_ninth);
            bits.push_back(1'b1);
            m_full = 0; m_tdre = 1;
          end
          m_busy = 1; m_tc = 0; m_ph = 0;
        end
      end else if (baud_tick) begin
        m_ph++;
        if (m_ph == 16) begin
          m_ph = 0;
          void'(bits.pop_front());
          if (bits.size() == 0) begin
            m_busy = 0;
            m_tc = !(m_full || m_brk || m_pre || m_sbk);
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_dr = wr_data; m_full = 1; m_tdre = 0; m_tc = 0; end
          2'd1: begin m_nine = wr_data[0]; m_ninth = wr_data[1]; end
          2'd2: begin
            if (was_busy && !m_te && wr_data[0]) m_pre = 1;
            if (!m_sbk && wr_data[1]) m_brk = 1;
            m_te = wr_data[0]; m_sbk = wr_data[1];
            m_tie = wr_data[2]; m_tcie = wr_data[3];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n && comparing) begin
      logic e_txd;
      e_txd = (m_te && m_busy) ? bits[0] : 1'b1;
      check(cur_req, "txd", txd, e_txd);
      check(cur_req, "tdre", tdre, m_tdre);
      check(cur_req, "tc", tc, m_tc);
      check(cur_req, "irq", irq, (m_tie && m_tdre) || (m_tcie && m_tc));
    end
  end

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % 4;
      baud_tick = (k == 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1", "txd", txd, 1'b1);
    check("R1", "tdre", tdre, 1'b1);
    check("R1", "tc", tc, 1'b1);
    check("R1", "irq", irq, 1'b0);
    comparing = 1'b1;

    cur_req = "R2";
    wr(2, 8'h01);
    wr(0, 8'hA5);
    idle(200);
    cur_req = "R11";
    wr(0, 8'h3C);
    check("R4", "tdre after write", tdre, 1'b0);
    idle(1600);

    cur_req = "R3";
    wr(1, 8'h03);
    wr(0, 8'h5A);
    idle(900);
    wr(1, 8'h01);
    wr(0, 8'hFF);
    idle(900);
    wr(1, 8'h00);

    cur_req = "R10";
    wr(2, 8'h05);
    wr(0, 8'h81);
    idle(20);
    check("R10", "irq with tdre", irq, 1'b1);
    wr(2, 8'h09);
    idle(900);
    check("R5", "tc at idle", tc, 1'b1);
    check("R10", "irq with tc", irq, 1'b1);

    cur_req = "R7";
    wr(2, 8'h01);
    wr(0, 8'h66);
    idle(100);
    wr(2, 8'h00);
    idle(10);
    wr(2, 8'h01);
    idle(1700);

    cur_req = "R8";
    wr(0, 8'h99);
    idle(100);
    wr(2, 8'h03);
    wr(2, 8'h01);
    idle(1700);
    wr(2, 8'h03);
    idle(2000);
    wr(2, 8'h01);
    idle(900);

    cur_req = "R9";
    wr(0, 8'h12);
    idle(50);
    wr(0, 8'h34);
    wr(2, 8'h03);
    wr(2, 8'h00);
    wr(2, 8'h01);
    idle(3400);

    cur_req = "R6";
    wr(2, 8'h00);
    wr(0, 8'hC3);
    idle(800);
    check("R6", "txd held with enable off", txd, 1'b1);
    check("R6", "byte still waiting", tdre, 1'b0);
    wr(2, 8'h01);
    idle(900);
    check("R5", "tc after resume", tc, 1'b1);

    finish_run();
  end
endmodule